// File: doc/BRIEF.md
# PSRAM Identify and Quad-Enable Sequencer

This block runs once after reset, before any memory-mapped access to an external serial PSRAM is allowed. It drives the SPI pins itself, through a small built-in serial engine clocked by a slow divided SCK. After a start pulse it sends a reset-enable command on all four data lines and then releases chip select. It then opens a second select period and reads the device identity: a read-ID command followed by six filler bytes. From that stream it takes the die-check byte and the extended identity byte.

The extended identity is decoded into a capacity in MiB and compared with the size the system expects. On a match the sequencer sends the enter-quad-mode command as a single-line transfer and reports done together with the detected size. On a mismatch it reports a size error and stops, with no quad-enable transfer. A skip input bypasses the identity read and reports the expected size as detected. Done and error both hold until the next reset.

Top module: `psram_id_boot`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, sio_oe is 0, done is 0, err_code is 0 and size_mib is 0.
- R2: The first select period after start carries command 0xF5 on four lines: sio_oe is 4'hF, high nibble first, two SCK cycles, and the response is discarded.
- R3: The second select period carries seven single-line bytes under one continuous cs_n low: 0x9F, then 0xFF six times. Each byte goes MSB first on sio_out[0] with sio_oe = 4'h1, and sio_in[1] is sampled on each rising SCK edge.
- R4: SCK idles low, rises to sample and falls to shift, and its rising edges are CLK_DIV system clocks apart.
- R5: cs_n stays high for at least GAP_CYC system clocks between two select periods.
- R6: The sixth received byte (position 5, counting from 0) must equal 0x5D. Any other value gives a detected size of 0.
- R7: With a good die byte, the seventh byte E decodes as follows: E = 0x26 gives 8; otherwise E[7:5] = 0, 1, 2 gives 2, 4, 8, and any other value gives 1 (all in MiB).
- R8: If the detected size differs from expected_mib, err_code becomes 2'b01, done stays 0, size_mib shows the detected size, and no third select period occurs.
- R9: On a match, a third select period sends 0x35 as a single-line byte (sio_oe = 4'h1). Then done becomes 1 with size_mib equal to expected_mib, which must be held stable during a run.
- R10: With skip_verify high at start, the identity period is omitted: 0xF5 is followed directly by 0x35, and done reports size_mib = expected_mib.
- R11: Done and error hold until reset, and start pulses in either state cause no new select period.
- R12: cs_n changes only while sck is 0 and sio_oe is 0, and while cs_n is high sck stays 0 and sio_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins the sequence from idle |
| skip_verify | input | 1 | Bypass the identity read (sampled at start) |
| expected_mib | input | SIZE_W | Expected capacity in MiB |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| sio_out | output | 4 | Serial data out, bit 0 for single-line mode |
| sio_oe | output | 4 | Per-line output enable |
| sio_in | input | 4 | Serial data in, bit 1 for single-line mode |
| done | output | 1 | Sequence completed with a size match |
| err_code | output | 2 | 0 means no error, 1 means size mismatch |
| size_mib | output | SIZE_W | Detected capacity in MiB |

## Verification
The hardest cases to reach from the ports are the decode corners: the 0x26 alias, whose upper bits alone would mean 4 MiB, and unlisted size codes that fall back to 1 MiB. Both live in byte positions the device only presents late in a 56-bit select period. The bench contains a device model that counts rising SCK edges inside each select period and presents a programmable seven-byte reply on sio_in[1]. Each scenario loads the die and identity bytes it needs and pairs them with a matching or mismatching expected size. The same model records every select period, so the bench can show that the quad-enable transfer is missing after an error and that start pulses are ignored.

// File: rtl/psram_id_pkg.sv
`timescale 1ns/1ps
package psram_id_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_RE_SEL,
        SQ_RE_PUSH,
        SQ_RE_WAIT,
        SQ_GAP1,
        SQ_ID_SEL,
        SQ_ID_PUSH,
        SQ_ID_WAIT,
        SQ_CHECK,
        SQ_GAP2,
        SQ_QE_SEL,
        SQ_QE_PUSH,
        SQ_QE_WAIT,
        SQ_DONE,
        SQ_ERR
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_SIZE = 2'd1
    } err_e;

    localparam logic [7:0] CMD_RESET_EN = 8'hF5;
    localparam logic [7:0] CMD_READ_ID  = 8'h9F;
    localparam logic [7:0] CMD_FILLER   = 8'hFF;
    localparam logic [7:0] CMD_QUAD_ON  = 8'h35;
    localparam logic [7:0] DIE_OK_BYTE  = 8'h5D;
    localparam logic [7:0] EID_8M_ALIAS = 8'h26;

    localparam int ID_XFERS = 7;
    localparam int DIE_POS  = 5;
    localparam int EID_POS  = 6;

endpackage

// File: rtl/psram_id_serial.sv
`timescale 1ns/1ps
module psram_id_serial #(
    parameter int CLK_DIV = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_byte,
    input  logic       push_quad,
    output logic       busy,
    output logic       tx_empty,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic [3:0] sio_out,
    output logic [3:0] sio_oe,
    input  logic [3:0] sio_in
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);

    typedef struct packed {
        logic             hold_v;
        logic [7:0]       hold_byte;
        logic             hold_quad;
        logic             busy;
        logic             quad;
        logic [7:0]       sh;
        logic [7:0]       rx;
        logic [3:0]       left;
        logic [DIV_W-1:0] div;
        logic             sck;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d = q;
        if (!q.busy && q.hold_v) begin
            d.busy   = 1'b1;
            d.quad   = q.hold_quad;
            d.sh     = q.hold_byte;
            d.left   = q.hold_quad ? 4'd2 : 4'd8;
            d.div    = '0;
            d.sck    = 1'b0;
            d.rx     = '0;
            d.hold_v = 1'b0;
        end else if (q.busy) begin
            if (q.div == DIV_LAST) begin
                d.div = '0;
                if (!q.sck) begin
                    d.sck = 1'b1;
                    d.rx  = q.quad ? {q.rx[3:0], sio_in} : {q.rx[6:0], sio_in[1]};
                end else begin
                    d.sck  = 1'b0;
                    d.sh   = q.quad ? {q.sh[3:0], 4'h0} : {q.sh[6:0], 1'b0};
                    d.left = q.left - 4'd1;
                    if (q.left == 4'd1) begin
                        d.busy = 1'b0;
                    end
                end
            end else begin
                d.div = q.div + 1'b1;
            end
        end
        if (push) begin
            d.hold_v    = 1'b1;
            d.hold_byte = push_byte;
            d.hold_quad = push_quad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = q.busy;
    assign tx_empty = !q.hold_v;
    assign rx_byte  = q.rx;
    assign sck      = q.sck;
    assign sio_out  = q.quad ? q.sh[7:4] : {3'b000, q.sh[7]};
    assign sio_oe   = q.busy ? (q.quad ? 4'hF : 4'h1) : 4'h0;

endmodule

// File: rtl/psram_id_size_decode.sv
`timescale 1ns/1ps
module psram_id_size_decode
    import psram_id_pkg::*;
#(
    parameter int SIZE_W = 4
) (
    input  logic [7:0]        die_byte,
    input  logic [7:0]        ext_id,
    output logic [SIZE_W-1:0] size_mib
);
    always_comb begin
        if (die_byte != DIE_OK_BYTE) begin
            size_mib = '0;
        end else if (ext_id == EID_8M_ALIAS || ext_id[7:5] == 3'd2) begin
            size_mib = SIZE_W'(8);
        end else if (ext_id[7:5] == 3'd0) begin
            size_mib = SIZE_W'(2);
        end else if (ext_id[7:5] == 3'd1) begin
            size_mib = SIZE_W'(4);
        end else begin
            size_mib = SIZE_W'(1);
        end
    end
endmodule

// File: rtl/psram_id_seq.sv
`timescale 1ns/1ps
module psram_id_seq
    import psram_id_pkg::*;
#(
    parameter int SIZE_W  = 4,
    parameter int GAP_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              skip_verify,
    input  logic [SIZE_W-1:0] expected_mib,
    input  logic              eng_ready,
    input  logic [7:0]        rx_byte,
    input  logic [SIZE_W-1:0] dec_size,
    output logic              push,
    output logic [7:0]        push_byte,
    output logic              push_quad,
    output logic              cs_n,
    output logic [7:0]        die_byte,
    output logic [7:0]        ext_id,
    output logic              done,
    output err_e              err_code,
    output logic [SIZE_W-1:0] size_mib
);
    localparam int GAP_W = $clog2(GAP_CYC + 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);
    localparam logic [2:0] DIE_IDX = 3'(DIE_POS);
    localparam logic [2:0] EID_IDX = 3'(EID_POS);

    typedef struct packed {
        seq_state_e        state;
        logic              cs_n;
        logic [GAP_W-1:0]  gap;
        logic [2:0]        idx;
        logic [7:0]        die;
        logic [7:0]        eid;
        logic [SIZE_W-1:0] size;
        logic              skip;
        logic [SIZE_W-1:0] expv;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d         = q;
        push      = 1'b0;
        push_byte = CMD_FILLER;
        push_quad = 1'b0;
        case (q.state)
            SQ_IDLE: begin
                if (start) begin
                    d.skip  = skip_verify;
                    d.expv  = expected_mib;
                    d.state = SQ_RE_SEL;
                end
            end
            SQ_RE_SEL: begin
                d.cs_n = 1'b0;
                if (eng_ready && !q.cs_n) begin
                    d.state = SQ_RE_PUSH;
                end
            end
            SQ_RE_PUSH: begin
                push      = 1'b1;
                push_byte = CMD_RESET_EN;
                push_quad = 1'b1;
                d.state   = SQ_RE_WAIT;
            end
            SQ_RE_WAIT: begin
                if (eng_ready) begin
                    d.cs_n  = 1'b1;
                    d.gap   = '0;
                    d.state = SQ_GAP1;
                end
            end
            SQ_GAP1: begin
                if (q.gap == GAP_LAST) begin
                    d.gap = '0;
                    if (q.skip) begin
                        d.size  = q.expv;
                        d.state = SQ_QE_SEL;
                    end else begin
                        d.state = SQ_ID_SEL;
                    end
                end else begin
                    d.gap = q.gap + 1'b1;
                end
            end
            SQ_ID_SEL: begin
                d.cs_n = 1'b0;
                d.idx  = '0;
                if (eng_ready && !q.cs_n) begin
                    d.state = SQ_ID_PUSH;
                end
            end
            SQ_ID_PUSH: begin
                push      = 1'b1;
                push_byte = (q.idx == 3'd0) ? CMD_READ_ID : CMD_FILLER;
                d.state   = SQ_ID_WAIT;
            end
            SQ_ID_WAIT: begin
                if (eng_ready) begin
                    if (q.idx == DIE_IDX) begin
                        d.die = rx_byte;
                    end
                    if (q.idx == EID_IDX) begin
                        d.eid   = rx_byte;
                        d.cs_n  = 1'b1;
                        d.state = SQ_CHECK;
                    end else begin
                        d.idx   = q.idx + 3'd1;
                        d.state = SQ_ID_PUSH;
                    end
                end
            end
            SQ_CHECK: begin
                d.size = dec_size;
                d.gap  = '0;
                if (dec_size != q.expv) begin
                    d.state = SQ_ERR;
                end else begin
                    d.state = SQ_GAP2;
                end
            end
            SQ_GAP2: begin
                if (q.gap == GAP_LAST) begin
                    d.gap   = '0;
                    d.state = SQ_QE_SEL;
                end else begin
                    d.gap = q.gap + 1'b1;
                end
            end
            SQ_QE_SEL: begin
                d.cs_n = 1'b0;
                if (eng_ready && !q.cs_n) begin
                    d.state = SQ_QE_PUSH;
                end
            end
            SQ_QE_PUSH: begin
                push      = 1'b1;
                push_byte = CMD_QUAD_ON;
                d.state   = SQ_QE_WAIT;
            end
            SQ_QE_WAIT: begin
                if (eng_ready) begin
                    d.cs_n  = 1'b1;
                    d.state = SQ_DONE;
                end
            end
            SQ_DONE: d.state = SQ_DONE;
            SQ_ERR:  d.state = SQ_ERR;
            default: d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= SQ_IDLE;
            q.cs_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cs_n     = q.cs_n;
    assign die_byte = q.die;
    assign ext_id   = q.eid;
    assign done     = (q.state == SQ_DONE);
    assign err_code = (q.state == SQ_ERR) ? ERR_SIZE : ERR_NONE;
    assign size_mib = q.size;

endmodule

// File: rtl/psram_id_boot.sv
`timescale 1ns/1ps
module psram_id_boot
    import psram_id_pkg::*;
#(
    parameter int SIZE_W  = 4,
    parameter int CLK_DIV = 10,
    parameter int GAP_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              skip_verify,
    input  logic [SIZE_W-1:0] expected_mib,
    output logic              sck,
    output logic              cs_n,
    output logic [3:0]        sio_out,
    output logic [3:0]        sio_oe,
    input  logic [3:0]        sio_in,
    output logic              done,
    output logic [1:0]        err_code,
    output logic [SIZE_W-1:0] size_mib
);
    logic              push_w;
    logic [7:0]        push_byte_w;
    logic              push_quad_w;
    logic              busy_w;
    logic              tx_empty_w;
    logic [7:0]        rx_byte_w;
    logic [7:0]        die_w;
    logic [7:0]        eid_w;
    logic [SIZE_W-1:0] dec_size_w;
    err_e              err_w;
    logic              ready_w;

    assign ready_w  = !busy_w && tx_empty_w;
    assign err_code = err_w;

    psram_id_serial #(.CLK_DIV(CLK_DIV)) i_serial (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_w),
        .push_byte (push_byte_w),
        .push_quad (push_quad_w),
        .busy      (busy_w),
        .tx_empty  (tx_empty_w),
        .rx_byte   (rx_byte_w),
        .sck       (sck),
        .sio_out   (sio_out),
        .sio_oe    (sio_oe),
        .sio_in    (sio_in)
    );

    psram_id_size_decode #(.SIZE_W(SIZE_W)) i_decode (
        .die_byte (die_w),
        .ext_id   (eid_w),
        .size_mib (dec_size_w)
    );

    psram_id_seq #(.SIZE_W(SIZE_W), .GAP_CYC(GAP_CYC)) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .skip_verify  (skip_verify),
        .expected_mib (expected_mib),
        .eng_ready    (ready_w),
        .rx_byte      (rx_byte_w),
        .dec_size     (dec_size_w),
        .push         (push_w),
        .push_byte    (push_byte_w),
        .push_quad    (push_quad_w),
        .cs_n         (cs_n),
        .die_byte     (die_w),
        .ext_id       (eid_w),
        .done         (done),
        .err_code     (err_w),
        .size_mib     (size_mib)
    );

endmodule

// File: rtl/psram_id_boot_chk.sv
`timescale 1ns/1ps
module psram_id_boot_chk #(
    parameter int SIZE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              skip_verify,
    input logic [SIZE_W-1:0] expected_mib,
    input logic              sck,
    input logic              cs_n,
    input logic [3:0]        sio_out,
    input logic [3:0]        sio_oe,
    input logic [3:0]        sio_in,
    input logic              done,
    input logic [1:0]        err_code,
    input logic [SIZE_W-1:0] size_mib
);
    assert_quiet_deselect_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sck && sio_oe == 4'h0));

    assert_cs_edge_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_n) |-> (!sck && sio_oe == 4'h0));

    assert_oe_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sio_oe == 4'h0 || sio_oe == 4'h1 || sio_oe == 4'hF));

    assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 2'd0) |=> (err_code == $past(err_code) && $stable(size_mib)));

    assert_done_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err_code != 2'd0));

    assert_done_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (size_mib == expected_mib));

    assert_end_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err_code != 2'd0) |-> cs_n);
endmodule

bind psram_id_boot psram_id_boot_chk #(.SIZE_W(SIZE_W)) i_chk (.*);

// File: tb/test_psram_id_boot.sv
`timescale 1ns/1ps
module test_psram_id_boot;
    localparam int SIZE_W  = 4;
    localparam int CLK_DIV = 10;
    localparam int GAP_CYC = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              skip_verify = 1'b0;
    logic [SIZE_W-1:0] expected_mib = '0;
    logic              sck, cs_n, done;
    logic [3:0]        sio_out, sio_oe, sio_in;
    logic [1:0]        err_code;
    logic [SIZE_W-1:0] size_mib;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    psram_id_boot #(.SIZE_W(SIZE_W), .CLK_DIV(CLK_DIV), .GAP_CYC(GAP_CYC)) i_psram_id_boot (
        .clk(clk), .rst_n(rst_n), .start(start), .skip_verify(skip_verify),
        .expected_mib(expected_mib), .sck(sck), .cs_n(cs_n), .sio_out(sio_out),
        .sio_oe(sio_oe), .sio_in(sio_in), .done(done), .err_code(err_code),
        .size_mib(size_mib)
    );

    // Device model and line monitor
    logic [7:0] reply [0:7];
    logic [7:0] fr_byte [0:3][0:7];
    int         fr_len [0:3];
    bit         fr_quad [0:3];
    int         fr_cnt;
    int         nbits, cyc, last_rise, period, rel_cyc, min_gap;
    bit         seen_rise, cs_prev, sck_prev;
    logic [7:0] acc;
    logic       miso;

    assign sio_in = {2'b00, miso, 1'b0};

    always @(negedge clk) begin
        if (!rst_n) begin
            fr_cnt = 0; nbits = 0; cyc = 0; period = 0; min_gap = 1000000;
            seen_rise = 0; cs_prev = 1; sck_prev = 0; acc = 0; miso = 0; rel_cyc = 0;
            for (int f = 0; f < 4; f++) begin
                fr_len[f] = 0; fr_quad[f] = 0;
                for (int b = 0; b < 8; b++) fr_byte[f][b] = 8'h00;
            end
        end else begin
            if (cs_prev && !cs_n) begin
                nbits = 0; acc = 0; seen_rise = 0;
                if (fr_cnt > 0 && (cyc - rel_cyc) < min_gap) min_gap = cyc - rel_cyc;
            end
            if (!cs_n && sck && !sck_prev) begin
                if (seen_rise) period = cyc - last_rise;
                seen_rise = 1; last_rise = cyc;
                if (sio_oe == 4'hF) begin
                    acc = {acc[3:0], sio_out}; nbits += 4;
                    if (fr_cnt < 4) fr_quad[fr_cnt] = 1;
                end else begin
                    acc = {acc[6:0], sio_out[0]}; nbits += 1;
                end
                if (nbits % 8 == 0 && nbits <= 64 && fr_cnt < 4) fr_byte[fr_cnt][nbits/8-1] = acc;
            end
            if (!cs_prev && cs_n) begin
                if (fr_cnt < 4) fr_len[fr_cnt] = nbits;
                fr_cnt++; rel_cyc = cyc;
            end
            miso = (nbits < 64) ? reply[nbits/8][7-(nbits%8)] : 1'b0;
            cs_prev = cs_n; sck_prev = sck; cyc++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_reply(input logic [7:0] die, input logic [7:0] eid);
        for (int i = 0; i < 8; i++) reply[i] = 8'h00;
        reply[5] = die;
        reply[6] = eid;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run_to_end(input string tag);
        int w = 0;
        pulse_start();
        while (!done && err_code == 2'd0 && w < 4000) begin
            @(negedge clk); w++;
        end
        check(w < 4000, {tag, " watchdog"}, w, 4000);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(cs_n == 1'b1 && sck == 1'b0 && sio_oe == 4'h0, "R1 lines idle", {cs_n, sck, sio_oe}, 6'b100000);
        check(done == 1'b0 && err_code == 2'd0 && size_mib == 0, "R1 status clear", {done, err_code, size_mib}, 0);
    endtask

    task automatic t_match_8m();
        do_reset(); set_reply(8'h5D, 8'h40); expected_mib = 4'd8; skip_verify = 0;
        run_to_end("R9");
        check(done == 1'b1 && err_code == 2'd0, "R9 done", {done, err_code}, 3'b100);
        check(size_mib == 4'd8, "R7 eid 0x40", size_mib, 8);
        check(fr_cnt == 3, "R9 three frames", fr_cnt, 3);
        check(fr_quad[0] && fr_len[0] == 8 && fr_byte[0][0] == 8'hF5, "R2 quad reset-enable",
              fr_byte[0][0], 8'hF5);
        check(!fr_quad[1] && fr_len[1] == 56, "R3 id length", fr_len[1], 56);
        check(fr_byte[1][0] == 8'h9F, "R3 id command", fr_byte[1][0], 8'h9F);
        for (int b = 1; b < 7; b++)
            check(fr_byte[1][b] == 8'hFF, "R3 filler", fr_byte[1][b], 8'hFF);
        check(!fr_quad[2] && fr_len[2] == 8 && fr_byte[2][0] == 8'h35, "R9 quad-enable single line",
              fr_byte[2][0], 8'h35);
        check(period == CLK_DIV, "R4 sck period", period, CLK_DIV);
        check(min_gap >= GAP_CYC, "R5 deselect gap", min_gap, GAP_CYC);
        pulse_start(); repeat (200) @(negedge clk);
        check(done == 1'b1 && fr_cnt == 3, "R11 start ignored after done", fr_cnt, 3);
    endtask

    task automatic t_size(input logic [7:0] eid, input int exp_mib, input string tag);
        do_reset(); set_reply(8'h5D, eid); expected_mib = exp_mib[SIZE_W-1:0]; skip_verify = 0;
        run_to_end(tag);
        check(done == 1'b1 && size_mib == exp_mib[SIZE_W-1:0], tag, size_mib, exp_mib);
    endtask

    task automatic t_bad_die();
        do_reset(); set_reply(8'h55, 8'h40); expected_mib = 4'd8; skip_verify = 0;
        run_to_end("R6");
        check(err_code == 2'd1 && done == 1'b0, "R6 bad die error", err_code, 1);
        check(size_mib == 0, "R6 bad die size zero", size_mib, 0);
        check(fr_cnt == 2, "R8 no quad-enable after error", fr_cnt, 2);
    endtask

    task automatic t_mismatch();
        do_reset(); set_reply(8'h5D, 8'h20); expected_mib = 4'd8; skip_verify = 0;
        run_to_end("R8");
        check(err_code == 2'd1, "R8 mismatch code", err_code, 1);
        check(size_mib == 4'd4, "R8 detected size shown", size_mib, 4);
        check(fr_cnt == 2, "R8 frames", fr_cnt, 2);
        pulse_start(); repeat (300) @(negedge clk);
        check(err_code == 2'd1 && fr_cnt == 2 && done == 1'b0, "R11 error holds", fr_cnt, 2);
    endtask

    task automatic t_skip();
        do_reset(); set_reply(8'h00, 8'h00); expected_mib = 4'd4; skip_verify = 1;
        run_to_end("R10");
        skip_verify = 0;
        check(done == 1'b1 && size_mib == 4'd4, "R10 skip reports expected", size_mib, 4);
        check(fr_cnt == 2, "R10 two frames", fr_cnt, 2);
        check(fr_byte[0][0] == 8'hF5 && fr_byte[1][0] == 8'h35 && fr_len[1] == 8, "R10 frame order",
              fr_byte[1][0], 8'h35);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) reply[i] = 8'h00;
        t_reset();
        t_match_8m();
        t_size(8'h00, 2, "R7 eid 0x00");
        t_size(8'h20, 4, "R7 eid 0x20");
        t_size(8'h26, 8, "R7 eid alias 0x26");
        t_size(8'h60, 1, "R7 eid other code");
        t_bad_die();
        t_mismatch();
        t_skip();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(150000 * 5);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule